// File: doc/BRIEF.md
# Shared-Term Programmable AND-OR Array

This block is a sum-of-products logic array whose whole function is held in a configuration register. Every logic input is offered to the AND plane as a pair of literals, one true and one inverted. For each product term, one configuration bit per literal decides whether that literal takes part. The OR plane then chooses, with one configuration bit per crossing, which product terms each sum term collects. A single product term may feed any number of sum terms at once. A function built from shared terms therefore costs no duplicate terms and no second logic level.

The sum terms are grouped four to a logic cell, with labels A, B, C and D. The logic cells are split into a lower group and an upper group. The product terms are split into two equal halves, and each half serves the cells of one group. A small set of global outputs sits beside the cells: the lowest product terms come out directly, and a few global sum terms may draw on every product term in either half. Evaluation is purely combinational. The configuration is shifted in through a word-wide port, and the word width may be set to one for a serial load.

Top module: `pla_share_array`

## Requirements
- R1: While reset is held and after it, until a load is done, the configuration is all zero. In that state every cell sum and every global sum reads 0, and every direct product-term output reads 1.
- R2: A product term with no literals enabled evaluates to 1. A sum term with no product terms connected evaluates to 0.
- R3: Input i offers a true literal at AND-row bit 2i and an inverted literal at bit 2i+1. Product term p uses configuration bits p*2*N_IN + 2i + {0,1}, and it is the AND of the literals that are enabled.
- R4: A product term that enables both literals of one input evaluates to 0 for any input value.
- R5: One product term may be connected to several sum terms at once, and each of them sees it.
- R6: Flat sum index s = cell*4 + label, with A=0, B=1, C=2 and D=3. Its OR bits sit at AND_BITS + s*(N_PT/2) + k, where k is the local term within the cell group's half. Cells below N_CELL/2 use product terms 0..N_PT/2-1; the other cells use N_PT/2..N_PT-1.
- R7: Cell sums appear on `cell_sum[s]` in flat sum-index order.
- R8: An N-bit mismatch function built from 2N shared product terms settles in the same cycle as its inputs. It drives the per-bit XOR sums and the wide OR sum together.
- R9: `glb_pt[g]` shows product term g. Global sum g uses bits AND_BITS + CELL_OR_BITS + g*N_PT + p and may draw on product terms from both halves.
- R10: When `cfg_en` is high, each clock shifts `cfg_word` in at the top of the configuration and moves the rest down by CFG_W. The first word of a load ends at bits [CFG_W-1:0] after TOTAL/CFG_W words. When `cfg_en` is low, the configuration holds and the outputs follow only the inputs.
- R11: With CFG_W = 1 the same bit layout loads one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration shift clock |
| rst_n | input | 1 | Asynchronous active-low reset, clears the configuration |
| cfg_en | input | 1 | Shift enable for the configuration |
| cfg_word | input | CFG_W | Configuration word shifted in at the top |
| x | input | N_IN | Logic inputs to the AND plane |
| cell_sum | output | N_CELL*4 | Sum terms of all logic cells, A..D per cell |
| glb_sum | output | N_GLB_SUM | Global sum terms over all product terms |
| glb_pt | output | N_GLB_PT | Lowest product terms routed out directly |

## Verification
The main instance is built with 32 inputs, 64 product terms, 10 logic cells and an 8-bit load word. This size fits a 16-bit mismatch function in one cell group: its 32 shared terms drive 16 XOR sums and one wide OR sum, and there is room left to show sharing that crosses cells and groups. A second instance uses 4 inputs, 4 product terms, 2 cells and a 1-bit load word. It exercises the serial variant and the split between the two halves at the smallest legal size.

// File: rtl/pla_pkg.sv
package pla_pkg;
   localparam int SUMS_PER_CELL = 4;

   // position of a literal in one AND row: true at 2i, inverted at 2i+1
   function automatic int lit_pos(input int idx, input bit inverted);
      return 2 * idx + (inverted ? 1 : 0);
   endfunction
endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
   parameter int TOTAL = 16,
   parameter int W     = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [W-1:0]     din,
   output logic [TOTAL-1:0] q
);
   if (TOTAL <= W || TOTAL % W != 0) begin : g_bad_len
      $error("pla_cfg_chain: TOTAL must be a multiple of W and larger than W");
   end

   if (W == 1) begin : g_serial
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q <= '0;
         else if (en) q <= {din[0], q[TOTAL-1:1]};
      end
   end else begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  q <= '0;
         else if (en) q <= {din, q[TOTAL-1:W]};
      end
   end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
   import pla_pkg::*;
#(
   parameter int N_IN = 8,
   parameter int N_PT = 16,
   localparam int N_LIT = 2 * N_IN
) (
   input  logic [N_IN-1:0]       x,
   input  logic [N_PT*N_LIT-1:0] cfg,
   output logic [N_PT-1:0]       pt
);
   logic [N_LIT-1:0] lit;

   for (genvar i = 0; i < N_IN; i++) begin : g_lit
      assign lit[lit_pos(i, 1'b0)] = x[i];
      assign lit[lit_pos(i, 1'b1)] = ~x[i];
   end

   // an unused literal is forced true, so an empty row gives 1
   for (genvar p = 0; p < N_PT; p++) begin : g_row
      assign pt[p] = &(lit | ~cfg[p*N_LIT +: N_LIT]);
   end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
   parameter int N_TERM = 8,
   parameter int N_SUM  = 8
) (
   input  logic [N_TERM-1:0]       pt,
   input  logic [N_SUM*N_TERM-1:0] cfg,
   output logic [N_SUM-1:0]        sum
);
   for (genvar s = 0; s < N_SUM; s++) begin : g_col
      assign sum[s] = |(pt & cfg[s*N_TERM +: N_TERM]);
   end
endmodule

// File: rtl/pla_share_array.sv
module pla_share_array
   import pla_pkg::*;
#(
   parameter int N_IN      = 8,
   parameter int N_PT      = 16,
   parameter int N_CELL    = 4,
   parameter int N_GLB_SUM = 2,
   parameter int N_GLB_PT  = 2,
   parameter int CFG_W     = 4,
   localparam int N_LIT     = 2 * N_IN,
   localparam int HALF_PT   = N_PT / 2,
   localparam int GRP_SUMS  = (N_CELL / 2) * SUMS_PER_CELL,
   localparam int N_SUMS    = N_CELL * SUMS_PER_CELL,
   localparam int AND_BITS  = N_PT * N_LIT,
   localparam int ORC_BITS  = N_SUMS * HALF_PT,
   localparam int GLB_BITS  = N_GLB_SUM * N_PT,
   localparam int TOTAL     = AND_BITS + ORC_BITS + GLB_BITS
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_en,
   input  logic [CFG_W-1:0]     cfg_word,
   input  logic [N_IN-1:0]      x,
   output logic [N_SUMS-1:0]    cell_sum,
   output logic [N_GLB_SUM-1:0] glb_sum,
   output logic [N_GLB_PT-1:0]  glb_pt
);
   if (N_IN < 1)                          begin : g_bad_in   $error("N_IN must be at least 1"); end
   if (N_PT < 2 || N_PT % 2 != 0)         begin : g_bad_pt   $error("N_PT must be even and at least 2"); end
   if (N_CELL < 2 || N_CELL % 2 != 0)     begin : g_bad_cell $error("N_CELL must be even and at least 2"); end
   if (N_GLB_SUM < 1)                     begin : g_bad_gs   $error("N_GLB_SUM must be at least 1"); end
   if (N_GLB_PT < 1 || N_GLB_PT > N_PT)   begin : g_bad_gp   $error("N_GLB_PT out of range"); end
   if (CFG_W < 1 || TOTAL % CFG_W != 0)   begin : g_bad_w    $error("CFG_W must divide the configuration length"); end

   logic [TOTAL-1:0] cfg_q;
   logic [N_PT-1:0]  pt;

   pla_cfg_chain #(.TOTAL(TOTAL), .W(CFG_W)) u_chain (
      .clk (clk),
      .rst_n (rst_n),
      .en  (cfg_en),
      .din (cfg_word),
      .q   (cfg_q)
   );

   pla_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
      .x   (x),
      .cfg (cfg_q[AND_BITS-1:0]),
      .pt  (pt)
   );

   // each half of the product terms serves one group of cells
   for (genvar g = 0; g < 2; g++) begin : g_grp
      pla_or_plane #(.N_TERM(HALF_PT), .N_SUM(GRP_SUMS)) u_or (
         .pt  (pt[g*HALF_PT +: HALF_PT]),
         .cfg (cfg_q[AND_BITS + g*GRP_SUMS*HALF_PT +: GRP_SUMS*HALF_PT]),
         .sum (cell_sum[g*GRP_SUMS +: GRP_SUMS])
      );
   end

   // global sums see every product term
   pla_or_plane #(.N_TERM(N_PT), .N_SUM(N_GLB_SUM)) u_glb (
      .pt  (pt),
      .cfg (cfg_q[AND_BITS + ORC_BITS +: GLB_BITS]),
      .sum (glb_sum)
   );

   assign glb_pt = pt[N_GLB_PT-1:0];
endmodule

// File: rtl/pla_share_array_chk.sv
module pla_share_array_chk
   import pla_pkg::*;
#(
   parameter int N_IN      = 8,
   parameter int N_PT      = 16,
   parameter int N_CELL    = 4,
   parameter int N_GLB_SUM = 2,
   parameter int N_GLB_PT  = 2,
   localparam int N_LIT    = 2 * N_IN,
   localparam int HALF_PT  = N_PT / 2,
   localparam int N_SUMS   = N_CELL * SUMS_PER_CELL,
   localparam int AND_BITS = N_PT * N_LIT,
   localparam int ORC_BITS = N_SUMS * HALF_PT,
   localparam int TOTAL    = AND_BITS + ORC_BITS + N_GLB_SUM * N_PT
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 cfg_en,
   input logic [N_IN-1:0]      x,
   input logic [TOTAL-1:0]     cfg_q,
   input logic [N_PT-1:0]      pt,
   input logic [N_SUMS-1:0]    cell_sum,
   input logic [N_GLB_SUM-1:0] glb_sum,
   input logic [N_GLB_PT-1:0]  glb_pt
);
   logic [N_PT-1:0]      clash, empty;
   logic [N_SUMS-1:0]    cell_dead;
   logic [N_GLB_SUM-1:0] glb_dead;

   always_comb begin
      for (int p = 0; p < N_PT; p++) begin
         clash[p] = 1'b0;
         for (int i = 0; i < N_IN; i++)
            clash[p] = clash[p] | (cfg_q[p*N_LIT + 2*i] & cfg_q[p*N_LIT + 2*i + 1]);
         empty[p] = (cfg_q[p*N_LIT +: N_LIT] == '0);
      end
      for (int s = 0; s < N_SUMS; s++)
         cell_dead[s] = (cfg_q[AND_BITS + s*HALF_PT +: HALF_PT] == '0);
      for (int g = 0; g < N_GLB_SUM; g++)
         glb_dead[g] = (cfg_q[AND_BITS + ORC_BITS + g*N_PT +: N_PT] == '0);
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cell_sum == '0 && glb_sum == '0 && glb_pt == '1));

   // R2
   empty_pt_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (empty & ~pt) == '0);

   // R2
   dead_sum_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cell_dead & cell_sum) == '0 && (glb_dead & glb_sum) == '0);

   // R4
   lit_clash_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clash & pt) == '0);

   // R10
   cfg_hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_en |=> ($stable(x) |-> ($stable(cell_sum) && $stable(glb_sum) && $stable(glb_pt))));
endmodule

bind pla_share_array pla_share_array_chk #(
   .N_IN(N_IN), .N_PT(N_PT), .N_CELL(N_CELL),
   .N_GLB_SUM(N_GLB_SUM), .N_GLB_PT(N_GLB_PT)
) u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .x(x), .cfg_q(cfg_q), .pt(pt),
   .cell_sum(cell_sum), .glb_sum(glb_sum), .glb_pt(glb_pt)
);

// File: tb/pla_share_array_bench.sv
module pla_share_array_bench;
   // main instance
   localparam int M_IN = 32, M_PT = 64, M_CELL = 10, M_GS = 2, M_GP = 2, M_W = 8;
   localparam int M_HALF = M_PT / 2;
   localparam int M_AND  = M_PT * 2 * M_IN;
   localparam int M_ORC  = M_CELL * 4 * M_HALF;
   localparam int M_TOT  = M_AND + M_ORC + M_GS * M_PT;
   // serial instance
   localparam int S_IN = 4, S_PT = 4, S_CELL = 2, S_GS = 1, S_GP = 1, S_W = 1;
   localparam int S_TOT = S_PT * 2 * S_IN + S_CELL * 4 * (S_PT / 2) + S_GS * S_PT;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic              m_en = 1'b0;
   logic [M_W-1:0]    m_word = '0;
   logic [M_IN-1:0]   m_x = '0;
   logic [M_CELL*4-1:0] m_cell;
   logic [M_GS-1:0]   m_gsum;
   logic [M_GP-1:0]   m_gpt;

   logic              s_en = 1'b0;
   logic [S_W-1:0]    s_word = '0;
   logic [S_IN-1:0]   s_x = '0;
   logic [S_CELL*4-1:0] s_cell;
   logic [S_GS-1:0]   s_gsum;
   logic [S_GP-1:0]   s_gpt;

   int checks = 0;
   int errors = 0;
   logic [M_TOT-1:0] cv;
   logic [S_TOT-1:0] sv;

   pla_share_array #(.N_IN(M_IN), .N_PT(M_PT), .N_CELL(M_CELL), .N_GLB_SUM(M_GS),
      .N_GLB_PT(M_GP), .CFG_W(M_W)) u_pla_share_array (
      .clk(clk), .rst_n(rst_n), .cfg_en(m_en), .cfg_word(m_word), .x(m_x),
      .cell_sum(m_cell), .glb_sum(m_gsum), .glb_pt(m_gpt));

   pla_share_array #(.N_IN(S_IN), .N_PT(S_PT), .N_CELL(S_CELL), .N_GLB_SUM(S_GS),
      .N_GLB_PT(S_GP), .CFG_W(S_W)) u_pla_share_array_ser (
      .clk(clk), .rst_n(rst_n), .cfg_en(s_en), .cfg_word(s_word), .x(s_x),
      .cell_sum(s_cell), .glb_sum(s_gsum), .glb_pt(s_gpt));

   // configuration layout as given in R3, R6 and R9
   function automatic int and_bit(int p, int i, bit inv);
      return p * 2 * M_IN + 2 * i + (inv ? 1 : 0);
   endfunction
   function automatic int orc_bit(int s, int k);
      return M_AND + s * M_HALF + k;
   endfunction
   function automatic int glb_bit(int g, int p);
      return M_AND + M_ORC + g * M_PT + p;
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic load_main();
      for (int w = 0; w < M_TOT / M_W; w++) begin
         @(negedge clk);
         m_en = 1'b1;
         m_word = cv[w*M_W +: M_W];
      end
      @(negedge clk);
      m_en = 1'b0;
   endtask

   task automatic load_ser();
      for (int w = 0; w < S_TOT; w++) begin
         @(negedge clk);
         s_en = 1'b1;
         s_word = sv[w];
      end
      @(negedge clk);
      s_en = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 cell sums", 64'(m_cell), 64'd0);
      chk("R1 global sums", 64'(m_gsum), 64'd0);
      chk("R1 direct terms", 64'(m_gpt), 64'(2'b11));
      chk("R1 serial cell sums", 64'(s_cell), 64'd0);
      chk("R1 serial direct term", 64'(s_gpt), 64'd1);
   endtask

   task automatic t_literals();
      logic [31:0] pats [4] = '{32'h0, 32'hFFFF_FFFF, 32'h9, 32'h12};
      logic [63:0] e;
      cv = '0;
      cv[and_bit(1, 0, 0)] = 1'b1;
      cv[and_bit(2, 1, 1)] = 1'b1;
      cv[and_bit(3, 2, 0)] = 1'b1;
      cv[and_bit(3, 2, 1)] = 1'b1;
      cv[and_bit(4, 3, 0)] = 1'b1;
      cv[and_bit(4, 4, 1)] = 1'b1;
      cv[orc_bit(0, 0)] = 1'b1;  // cell0 A <- empty term 0
      cv[orc_bit(1, 1)] = 1'b1;  // cell0 B
      cv[orc_bit(2, 2)] = 1'b1;  // cell0 C
      cv[orc_bit(3, 3)] = 1'b1;  // cell0 D <- clashing term
      cv[orc_bit(4, 4)] = 1'b1;  // cell1 A
      load_main();
      foreach (pats[n]) begin
         m_x = pats[n];
         #1;
         e = '0;
         e[0] = 1'b1;
         e[1] = pats[n][0];
         e[2] = ~pats[n][1];
         e[3] = 1'b0;
         e[4] = pats[n][3] & ~pats[n][4];
         chk("R2 R3 R4 R7 literal sums", 64'(m_cell), e);
         chk("R9 direct terms", 64'(m_gpt), 64'({pats[n][0], 1'b1}));
         chk("R2 unconnected global sums", 64'(m_gsum), 64'd0);
      end
   endtask

   task automatic t_sharing();
      logic [31:0] pats [4] = '{32'h0, 32'h60, 32'h180, 32'h20};
      logic [63:0] e;
      logic sh;
      cv = '0;
      cv[and_bit(5, 5, 0)] = 1'b1;
      cv[and_bit(5, 6, 0)] = 1'b1;
      cv[and_bit(32, 7, 0)] = 1'b1;
      cv[and_bit(33, 8, 1)] = 1'b1;
      cv[orc_bit(5, 5)]  = 1'b1;  // cell1 B
      cv[orc_bit(10, 5)] = 1'b1;  // cell2 C
      cv[orc_bit(19, 5)] = 1'b1;  // cell4 D
      cv[orc_bit(20, 0)] = 1'b1;  // cell5 A, upper group, local 0 = term 32
      cv[glb_bit(0, 5)]  = 1'b1;
      cv[glb_bit(1, 5)]  = 1'b1;
      cv[glb_bit(1, 33)] = 1'b1;
      load_main();
      foreach (pats[n]) begin
         m_x = pats[n];
         #1;
         sh = pats[n][5] & pats[n][6];
         e = '0;
         e[5] = sh;
         e[10] = sh;
         e[19] = sh;
         e[20] = pats[n][7];
         chk("R5 R6 shared term cell sums", 64'(m_cell), e);
         chk("R9 global sums across halves", 64'(m_gsum), 64'({sh | ~pats[n][8], sh}));
      end
   endtask

   task automatic t_compare();
      logic [31:0] pats [5] = '{32'h1234_1234, 32'h1234_9234, 32'hFFFF_0000, 32'h0001_0000, 32'hA5A5_5A5A};
      logic [63:0] e;
      logic [15:0] a, b;
      cv = '0;
      for (int i = 0; i < 16; i++) begin
         cv[and_bit(2*i, i, 0)] = 1'b1;
         cv[and_bit(2*i, 16+i, 1)] = 1'b1;
         cv[and_bit(2*i+1, i, 1)] = 1'b1;
         cv[and_bit(2*i+1, 16+i, 0)] = 1'b1;
         cv[orc_bit(i, 2*i)] = 1'b1;
         cv[orc_bit(i, 2*i+1)] = 1'b1;
      end
      for (int k = 0; k < 32; k++) cv[orc_bit(16, k)] = 1'b1;
      load_main();
      foreach (pats[n]) begin
         m_x = pats[n];
         #1;  // same cycle, no clock edge in between
         a = pats[n][15:0];
         b = pats[n][31:16];
         e = '0;
         e[15:0] = a ^ b;
         e[16] = (a != b);
         chk("R8 mismatch sums same cycle", 64'(m_cell), e);
         chk("R9 direct terms of compare", 64'(m_gpt), 64'({~a[0] & b[0], a[0] & ~b[0]}));
      end
   endtask

   task automatic t_hold();
      logic [63:0] e;
      m_x = 32'h0F0F_0F00;
      e = '0;
      e[15:0] = 16'h0F00 ^ 16'h0F0F;
      e[16] = 1'b1;
      for (int c = 0; c < 12; c++) begin
         @(negedge clk);
         m_word = 8'(c * 37 + 5);
         #1;
         chk("R10 outputs hold while load disabled", 64'(m_cell), e);
      end
   endtask

   task automatic t_serial();
      logic [3:0] pats [4] = '{4'b0001, 4'b0011, 4'b1000, 4'b1001};
      logic [63:0] e;
      logic p0, p2;
      sv = '0;
      sv[0] = 1'b1;   // term0 x0 true
      sv[3] = 1'b1;   // term0 x1 inverted
      sv[22] = 1'b1;  // term2 x3 true
      sv[36] = 1'b1;  // cell0 C <- local 0
      sv[40] = 1'b1;  // cell1 A <- local 0 of upper half = term2
      sv[48] = 1'b1;  // global sum <- term0
      sv[50] = 1'b1;  // global sum <- term2
      load_ser();
      foreach (pats[n]) begin
         s_x = pats[n];
         #1;
         p0 = pats[n][0] & ~pats[n][1];
         p2 = pats[n][3];
         e = '0;
         e[2] = p0;
         e[4] = p2;
         chk("R11 serial cell sums", 64'(s_cell), e);
         chk("R11 serial global sum", 64'(s_gsum), 64'(p0 | p2));
         chk("R11 serial direct term", 64'(s_gpt), 64'(p0));
      end
   endtask

   initial begin
      #500us;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      #1;
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_literals();
      t_sharing();
      t_compare();
      t_hold();
      t_serial();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule